// File: doc/BRIEF.md
# Audio Playback Sample FIFO with DMA Request

This block buffers outgoing audio samples on their way to a DAC. Software or a DMA engine writes samples into a data register on a simple 32-bit register port. The block stores them in a 64-entry, 24-bit FIFO and pulls one frame out at every sample tick. A frame is one entry in mono mode and a left/right pair in stereo mode. The frame is presented on two 24-bit output ports together with a one-cycle strobe.

Incoming words are turned into 24-bit samples. A 16-bit sample is widened either by zero padding or by repeating its upper byte. A 24-bit sample is taken from the top of a 32-bit word. A DMA request output with separate rise and fall thresholds keeps the FIFO topped up. When the FIFO runs dry at a tick, the block outputs either silence or the previous frame, as software selects. The sample tick comes from a divider of the module clock, and a 3-bit rate code picks the ratio. The same code covers the 48 kHz family and the 44.1 kHz family; which one results depends on the module clock frequency supplied.

Top module: `dtx_playback_fifo`

## Requirements
- R1: After reset the control register reads 0, the status register reports 64 free slots with the overrun flag clear, the DMA request is low, and both sample outputs are 0.
- R2: Register offsets are 0x04 for control, 0x08 for status and 0x0C for transmit data. Control reads back all writable bits (31:28, 26, 24, 22:21, 13:8, 6:4), while bit 0 always reads 0. Status bits 6:0 hold the free-slot count and bit 8 holds the overrun flag.
- R3: Writing control with bit 0 set empties the FIFO, so the free count returns to 64.
- R4: While control bit 4 is 0, the DMA request is low whatever the FIFO level.
- R5: With bit 4 set, the request rises when the free count exceeds the 6-bit level in bits 13:8. It falls when the free count drops below 2 shifted left by the code in bits 22:21 (code 3 gives 16). Between the two thresholds it holds its value.
- R6: With bit 5 = 0, a sample is the low 16 bits of the write, placed in output bits 23:8. Bits 7:0 are zero when bit 24 = 0, and a copy of the sample's upper byte when bit 24 = 1.
- R7: With bit 5 = 1, a sample is bits 31:8 of the write, and bit 24 has no effect.
- R8: In stereo mode (bit 6 = 0), each tick takes two entries: the first goes to the left output, the second to the right. In mono mode (bit 6 = 1), each tick takes one entry and drives it to both outputs.
- R9: At a tick without a full frame stored (none in mono, fewer than two in stereo), nothing is removed from the FIFO. The outputs become 0 when bit 26 = 0, and keep their previous frame when bit 26 = 1.
- R10: The tick period in module clocks for rate codes 0..7 (bits 31:29) is 512, 768, 1024, 1536, 2048, 3072, 128 and 256. `frame_strobe` is high for one cycle per tick, in the cycle where the outputs take the new frame.
- R11: A data write while the FIFO is full is discarded and sets the sticky overrun flag. Only a flush clears that flag.
- R12: Bit 28 (filter length select) is stored and read back, and has no effect on the sample path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| dma_req | output | 1 | DMA request for more samples |
| left_out | output | 24 | Left channel sample |
| right_out | output | 24 | Right channel sample |
| frame_strobe | output | 1 | One-cycle pulse when a new frame is presented |

## Verification
The sample path gets distinct 16-bit values in both alignment modes, so zero padding and upper-byte repetition give different low bytes. It also gets 32-bit words with a non-zero low byte, which shows that 24-bit mode drops those bits. Stereo pairs use different left and right values, so a swapped order is visible. The mono path is compared against them. Underrun is tried with an empty FIFO and with a single stored entry in stereo, under both policies; this tells apart output of silence, repetition of the frame, and a wrong pop. The request is moved through its hold band in both directions, and the tick period is measured for several rate codes.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_DATA = 8'h0C;
  localparam logic [31:0] CTRL_WMASK = 32'hF560_3F70;

  // Module clocks per sample tick for each rate code.
  function automatic logic [11:0] tick_ratio(input logic [2:0] code);
    case (code)
      3'd0: tick_ratio = 12'd512;
      3'd1: tick_ratio = 12'd768;
      3'd2: tick_ratio = 12'd1024;
      3'd3: tick_ratio = 12'd1536;
      3'd4: tick_ratio = 12'd2048;
      3'd5: tick_ratio = 12'd3072;
      3'd6: tick_ratio = 12'd128;
      default: tick_ratio = 12'd256;
    endcase
  endfunction

  // Turn one bus word into a 24-bit sample.
  function automatic logic [23:0] fmt_sample(input logic [31:0] w,
                                             input logic wide,
                                             input logic rep);
    if (wide) fmt_sample = w[31:8];
    else if (rep) fmt_sample = {w[15:0], w[15:8]};
    else fmt_sample = {w[15:0], 8'h00};
  endfunction

  // Fall threshold of the DMA request.
  function automatic logic [7:0] clr_level(input logic [1:0] code);
    clr_level = 8'd2 << code;
  endfunction
endpackage

// File: rtl/dtx_fifo.sv
module dtx_fifo #(
  parameter int DEPTH = 64,
  parameter int W = 24,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic [1:0]    pop_cnt,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [CW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] rd_idx1;

  assign count   = wr_ptr - rd_ptr;
  assign rd_idx1 = rd_ptr[AW-1:0] + AW'(1);
  assign head0   = mem[rd_ptr[AW-1:0]];
  assign head1   = mem[rd_idx1];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + CW'(1);
      rd_ptr <= rd_ptr + CW'(pop_cnt);
    end
  end

  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/dtx_tick_div.sv
module dtx_tick_div #(
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  output logic       tick
);
  import dtx_pkg::*;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last = CNT_W'(tick_ratio(code) - 12'd1);
  assign tick = cnt >= last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  // every ratio is at least 128, so ticks never come back to back
  a_r10_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dtx_dreq.sv
module dtx_dreq #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] free,
  input  logic [5:0]    trig,
  input  logic [1:0]    clr_code,
  output logic          req
);
  import dtx_pkg::*;
  logic rise_w, fall_w;

  assign rise_w = 8'(free) > 8'(trig);
  assign fall_w = 8'(free) < clr_level(clr_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else if (!en) req <= 1'b0;
    else if (rise_w) req <= 1'b1;
    else if (fall_w) req <= 1'b0;
  end

  a_r4_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !req);
  a_r5_req_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rise_w) |=> req);
endmodule

// File: rtl/dtx_playback_fifo.sv
module dtx_playback_fifo #(
  parameter int DEPTH = 64,
  parameter int SW = 24,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [7:0]    rd_addr,
  output logic [31:0]   rd_data,
  output logic          dma_req,
  output logic [SW-1:0] left_out,
  output logic [SW-1:0] right_out,
  output logic          frame_strobe
);
  import dtx_pkg::*;

  logic [31:0] ctrl;
  logic        ovr_flag;

  // control fields
  logic [2:0] f_rate;
  logic       f_last, f_rep, f_mono, f_wide, f_dma;
  logic [1:0] f_clr;
  logic [5:0] f_trig;
  assign f_rate = ctrl[31:29];
  assign f_last = ctrl[26];
  assign f_rep  = ctrl[24];
  assign f_clr  = ctrl[22:21];
  assign f_trig = ctrl[13:8];
  assign f_mono = ctrl[6];
  assign f_wide = ctrl[5];
  assign f_dma  = ctrl[4];

  // named events
  logic ctrl_wr_w, flush_w, data_wr_w, push_w, drop_w, tick_w, underrun_w;
  logic [1:0]    pop_w;
  logic [CW-1:0] count_w, free_w;
  logic [SW-1:0] head0_w, head1_w;

  assign ctrl_wr_w = wr_en && (wr_addr == OFS_CTRL);
  assign flush_w   = ctrl_wr_w && wr_data[0];
  assign data_wr_w = wr_en && (wr_addr == OFS_DATA);
  assign free_w    = CW'(DEPTH) - count_w;
  assign push_w    = data_wr_w && (free_w != '0);
  assign drop_w    = data_wr_w && (free_w == '0);

  always_comb begin
    pop_w      = 2'd0;
    underrun_w = 1'b0;
    if (tick_w && !flush_w) begin
      if (f_mono) begin
        if (count_w >= CW'(1)) pop_w = 2'd1;
        else underrun_w = 1'b1;
      end else begin
        if (count_w >= CW'(2)) pop_w = 2'd2;
        else underrun_w = 1'b1;
      end
    end
  end

  dtx_fifo #(.DEPTH(DEPTH), .W(SW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_w), .push(push_w),
    .push_data(fmt_sample(wr_data, f_wide, f_rep)), .pop_cnt(pop_w),
    .head0(head0_w), .head1(head1_w), .count(count_w)
  );

  dtx_tick_div #(.CNT_W(12)) u_div (
    .clk(clk), .rst_n(rst_n), .code(f_rate), .tick(tick_w)
  );

  dtx_dreq #(.CW(CW)) u_dreq (
    .clk(clk), .rst_n(rst_n), .en(f_dma), .free(free_w),
    .trig(f_trig), .clr_code(f_clr), .req(dma_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      ovr_flag <= 1'b0;
    end else begin
      if (ctrl_wr_w) ctrl <= wr_data & CTRL_WMASK;
      if (flush_w) ovr_flag <= 1'b0;
      else if (drop_w) ovr_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_out     <= '0;
      right_out    <= '0;
      frame_strobe <= 1'b0;
    end else begin
      frame_strobe <= tick_w;
      if (pop_w == 2'd1) begin
        left_out  <= head0_w;
        right_out <= head0_w;
      end else if (pop_w == 2'd2) begin
        left_out  <= head0_w;
        right_out <= head1_w;
      end else if (underrun_w && !f_last) begin
        left_out  <= '0;
        right_out <= '0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFS_CTRL) rd_data = ctrl;
    else if (rd_addr == OFS_STAT) begin
      rd_data[CW-1:0] = free_w;
      rd_data[8]      = ovr_flag;
    end
  end

  a_r9_zero_on_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_w && !f_last) |=> (left_out == '0 && right_out == '0));
  a_r9_hold_on_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun_w && f_last) |=> ($stable(left_out) && $stable(right_out)));
  a_r11_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_w && pop_w == 2'd0) |=> $stable(count_w));
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !flush_w) |=> ovr_flag);
endmodule

// File: tb/tb_dtx_playback_fifo.sv
module tb_dtx_playback_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        dma_req;
  logic [23:0] left_out, right_out;
  logic        frame_strobe;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dtx_playback_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dma_req(dma_req), .left_out(left_out), .right_out(right_out),
    .frame_strobe(frame_strobe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] code, input logic fir,
      input logic last, input logic rep, input logic [1:0] clr, input logic [5:0] trig,
      input logic mono, input logic w24, input logic dma);
    mk = {code, fir, 1'b0, last, 1'b0, rep, 1'b0, clr, 7'b0, trig,
          1'b0, mono, w24, dma, 4'b0};
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push_n(input int n, input logic [31:0] base);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_addr = 8'h0C; wr_data = base + 32'(i);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!frame_strobe);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    bus_wr(8'h04, v | 32'h1);
    bus_wr(8'h04, v);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h04, d); chk("R1 ctrl after reset", d, 32'h0);
    bus_rd(8'h08, d); chk("R1 status after reset", d, 32'd64);
    chk("R1 dma_req after reset", {31'b0, dma_req}, 32'h0);
    chk("R1 outputs after reset", {8'b0, left_out}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, d); chk("R2 R12 ctrl readback mask", d, 32'hF560_3F70);
    set_ctrl(32'h0);
    bus_rd(8'h04, d); chk("R2 ctrl cleared", d, 32'h0);
  endtask

  task automatic t_fmt16();
    logic [31:0] v;
    v = mk(3'd6, 1'b1, 1'b0, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 1'b0);
    set_ctrl(v);
    wait_strobe(); bus_wr(8'h0C, 32'h5555_1234); bus_wr(8'h0C, 32'h0000_ABCD);
    wait_strobe();
    chk("R6 R8 zero pad left", {8'b0, left_out}, 32'h0012_3400);
    chk("R6 R8 zero pad right", {8'b0, right_out}, 32'h00AB_CD00);
    set_ctrl(v | 32'h0100_0000);
    wait_strobe(); bus_wr(8'h0C, 32'h0000_1234); bus_wr(8'h0C, 32'h0000_ABCD);
    wait_strobe();
    chk("R6 msb repeat left", {8'b0, left_out}, 32'h0012_3412);
    chk("R6 msb repeat right", {8'b0, right_out}, 32'h00AB_CDAB);
  endtask

  task automatic t_fmt24_mono();
    logic [31:0] v;
    v = mk(3'd6, 1'b0, 1'b0, 1'b1, 2'd0, 6'd0, 1'b0, 1'b1, 1'b0);
    set_ctrl(v);
    wait_strobe(); bus_wr(8'h0C, 32'hA1B2_C3FF); bus_wr(8'h0C, 32'h1020_3044);
    wait_strobe();
    chk("R7 24-bit left", {8'b0, left_out}, 32'h00A1_B2C3);
    chk("R7 24-bit right", {8'b0, right_out}, 32'h0010_2030);
    set_ctrl(v | 32'h40);
    wait_strobe(); bus_wr(8'h0C, 32'h7766_5500); bus_wr(8'h0C, 32'h1122_3300);
    wait_strobe();
    chk("R8 mono left", {8'b0, left_out}, 32'h0077_6655);
    chk("R8 mono right", {8'b0, right_out}, 32'h0077_6655);
    wait_strobe();
    chk("R8 mono second entry", {8'b0, right_out}, 32'h0011_2233);
  endtask

  task automatic t_underrun();
    logic [31:0] v, d;
    v = mk(3'd6, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 1'b0);
    set_ctrl(v);
    wait_strobe(); bus_wr(8'h0C, 32'h1111); bus_wr(8'h0C, 32'h2222);
    wait_strobe(); wait_strobe();
    chk("R9 zero underrun left", {8'b0, left_out}, 32'h0);
    set_ctrl(v | 32'h0400_0000);
    wait_strobe(); bus_wr(8'h0C, 32'h3333); bus_wr(8'h0C, 32'h4444);
    wait_strobe(); wait_strobe();
    chk("R9 repeat left", {8'b0, left_out}, 32'h0033_3300);
    chk("R9 repeat right", {8'b0, right_out}, 32'h0044_4400);
    bus_wr(8'h0C, 32'h5555);
    wait_strobe();
    chk("R9 single entry kept left", {8'b0, left_out}, 32'h0033_3300);
    bus_rd(8'h08, d); chk("R9 single entry not popped", d, 32'd63);
    set_ctrl(v);
    bus_rd(8'h08, d); chk("R3 flush empties", d, 32'd64);
    wait_strobe();
    chk("R3 after flush underrun", {8'b0, left_out}, 32'h0);
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    set_ctrl(mk(3'd5, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 1'b0));
    wait_strobe();
    push_n(5, 32'h100);
    bus_rd(8'h08, d); chk("R2 free count", d, 32'd59);
    push_n(61, 32'h200);
    bus_rd(8'h08, d); chk("R11 full with overrun", d, 32'h0000_0100);
    wait_strobe();
    chk("R11 first kept entry", {8'b0, left_out}, 32'h0001_0000);
    bus_rd(8'h08, d); chk("R11 flag sticky after drain", d, 32'h0000_0102);
    bus_wr(8'h04, 32'hA000_0001);
    bus_rd(8'h08, d); chk("R11 R3 flush clears flag", d, 32'd64);
  endtask

  task automatic t_dma();
    logic [31:0] v;
    v = mk(3'd5, 1'b0, 1'b0, 1'b0, 2'd3, 6'd0, 1'b0, 1'b0, 1'b0);
    set_ctrl(v); idle(3);
    chk("R4 no request when disabled", {31'b0, dma_req}, 32'h0);
    v = mk(3'd5, 1'b0, 1'b0, 1'b0, 2'd3, 6'd40, 1'b0, 1'b0, 1'b1);
    set_ctrl(v); idle(3);
    chk("R5 rise when free 64", {31'b0, dma_req}, 32'h1);
    wait_strobe();
    push_n(34, 32'h0); idle(2);
    chk("R5 hold high at free 30", {31'b0, dma_req}, 32'h1);
    push_n(15, 32'h0); idle(2);
    chk("R5 fall at free 15", {31'b0, dma_req}, 32'h0);
    wait_strobe(); idle(2);
    chk("R5 hold low at free 17", {31'b0, dma_req}, 32'h0);
    bus_wr(8'h04, v & ~32'h10); idle(2);
    bus_wr(8'h04, v | 32'h1); idle(2);
    chk("R5 rise after flush", {31'b0, dma_req}, 32'h1);
    bus_wr(8'h04, v & ~32'h10); idle(2);
    chk("R4 request drops when disabled", {31'b0, dma_req}, 32'h0);
  endtask

  task automatic t_rate(input logic [2:0] code, input int exp);
    int n;
    set_ctrl(mk(code, 1'b0, 1'b0, 1'b0, 2'd0, 6'd0, 1'b0, 1'b0, 1'b0));
    wait_strobe(); wait_strobe();
    n = 0;
    do begin @(negedge clk); n++; end while (!frame_strobe);
    chk($sformatf("R10 period code %0d", code), 32'(n), 32'(exp));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_regs();
    t_fmt16();
    t_fmt24_mono();
    t_underrun();
    t_overrun();
    t_dma();
    t_rate(3'd6, 128);
    t_rate(3'd7, 256);
    t_rate(3'd1, 768);
    t_rate(3'd0, 512);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule